// File: doc/BRIEF.md
# Handshaked Byte-Wide Command Bus Slave

This block sits on the chip side of an 8-bit parallel bus that a microcontroller drives. Neither side shares a clock with the other. The host opens a transaction by raising a start line. It then moves bytes one at a time. Each byte uses a four-phase strobe pair: the host raises its strobe, the slave answers with its own strobe, the host drops its strobe, and the slave drops its own. The slave holds an acknowledge line high for the whole transaction. The host waits for acknowledge to fall before it drops start. All host control lines pass through two-flop synchronisers before the slave looks at them.

A transaction has two phases. First the host writes a six-byte command: an opcode, an 8-bit register address, and a 32-bit data word sent least significant byte first. The slave then checks the command and, if it is valid, performs one access on an internal register-file port. Second, the host reads back a reply of whole 32-bit words, also least significant byte first. Word 0 holds the read data and word 1 holds a completion status code.

Register 0 is served inside the block. It is read-only and describes how many units of each kind sit behind the port. Software uses it to find where each group of banks starts. Unit banks begin at address 1 in a fixed order: pulse-width banks, then encoder banks, then one servo bank. An address above the last bank is refused with an error status, and the bus still completes normally.

Top module: `hbus_slave`

## Requirements
- R1: After the asynchronous active-low reset, `slv_ack`, `slv_stb` and `bus_oe` are low.
- R2: A rising `host_start` raises `slv_ack`. `slv_ack` stays high until the handshake of the last reply byte has finished and then falls. If `host_start` falls before that point, the slave abandons the transaction, drops `slv_ack`, and serves the next transaction normally.
- R3: For every byte, `slv_stb` rises only while the synchronised `host_stb` is high, and falls only while it is low (four-phase handshake).
- R4: The command is six host-written bytes in this order: opcode, address, then data bits [7:0], [15:8], [23:16], [31:24]. Opcode 8'h01 is a read and opcode 8'h02 is a write.
- R5: The reply is `REPLY_WORDS` words of four bytes each, every word sent least significant byte first. Word 0 is the read data, and is zero for a write or any error. Word 1 is the status code in bits [7:0] with zeros above it. Words 2 and up are zero.
- R6: A valid command drives `rf_valid` for exactly one cycle, with `rf_addr` and `rf_wdata` from the command and `rf_we` high for a write. A valid read returns `rf_rdata` in reply word 0. Status 0 means success.
- R7: A read of address 0 returns, without any port access, the value {12'h0, N_SERVO[3:0], N_ENC[3:0], N_PWM[3:0], VER_MINOR[3:0], VER_MAJOR[3:0]}. A write to address 0 makes no port access, returns status 3, and leaves the register unchanged.
- R8: An opcode other than 8'h01 or 8'h02 returns status 1 and makes no port access. This check takes priority over the address checks.
- R9: The last valid address is N_PWM*PWM_REGS + N_ENC*ENC_REGS + SERVO_REGS. Any address above it returns status 2 and makes no port access.
- R10: `bus_oe` is high only during the reply phase while the synchronised `host_rnw` is high, and it is low outside a transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Transaction open line from the host |
| host_rnw | input | 1 | Byte direction: 1 = host reads, 0 = host writes |
| host_stb | input | 1 | Host byte strobe |
| bus_din | input | 8 | Data driven by the host |
| bus_dout | output | 8 | Reply byte driven by the slave |
| bus_oe | output | 1 | Slave drives the data bus |
| slv_stb | output | 1 | Slave byte strobe answer |
| slv_ack | output | 1 | Transaction busy acknowledge |
| rf_valid | output | 1 | Register port access pulse |
| rf_we | output | 1 | Register port write enable |
| rf_addr | output | 8 | Register port address |
| rf_wdata | output | 32 | Register port write data |
| rf_rdata | input | 32 | Register port read data, combinational |

## Verification
The bench builds the slave with 2 pulse-width banks of 3 registers, 1 encoder bank of 4 registers, a servo bank of 3 registers, 5 servo channels and 3 reply words. With these values the last valid address is 13, so both the first address past the range (14) and the range top can be reached in a few transactions. The third reply word lets the bench check that words beyond the status word come back zero. The distinct small counts, together with versions 3.7, make every field of register 0 visible and different from its neighbours.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_EXEC,
        ST_SEND,
        ST_DONE
    } hbus_state_e;

    localparam logic [7:0] OPC_READ  = 8'h01;
    localparam logic [7:0] OPC_WRITE = 8'h02;

    localparam logic [7:0] STS_OK       = 8'd0;
    localparam logic [7:0] STS_BAD_OPC  = 8'd1;
    localparam logic [7:0] STS_BAD_ADDR = 8'd2;
    localparam logic [7:0] STS_RO_WRITE = 8'd3;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] held_q, held_d;

    always_comb begin
        meta_d = async_i;
        held_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            held_q <= '0;
        end else begin
            meta_q <= meta_d;
            held_q <= held_d;
        end
    end

    assign sync_o = held_q;
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
#(
    parameter int ADDR_TOP  = 38,
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 0,
    parameter int N_PWM     = 4,
    parameter int N_ENC     = 2,
    parameter int N_SERVO   = 8
) (
    input  logic [7:0]  opc_i,
    input  logic [7:0]  adr_i,
    output logic [7:0]  code_o,
    output logic [31:0] info_o
);
    logic opc_known;

    always_comb begin
        opc_known = (opc_i == OPC_READ) || (opc_i == OPC_WRITE);
        if (!opc_known)
            code_o = STS_BAD_OPC;
        else if (int'(adr_i) > ADDR_TOP)
            code_o = STS_BAD_ADDR;
        else if (adr_i == 8'd0 && opc_i == OPC_WRITE)
            code_o = STS_RO_WRITE;
        else
            code_o = STS_OK;
    end

    assign info_o = {12'h000, 4'(N_SERVO), 4'(N_ENC), 4'(N_PWM),
                     4'(VER_MINOR), 4'(VER_MAJOR)};

    always_comb begin
        if (code_o == STS_OK)
            assert (opc_known && int'(adr_i) <= ADDR_TOP)
                else $error("p_ok_only_valid_r8 failed");
    end
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int VER_MAJOR   = 1,
    parameter int VER_MINOR   = 0,
    parameter int N_PWM       = 4,
    parameter int PWM_REGS    = 4,
    parameter int N_ENC       = 2,
    parameter int ENC_REGS    = 6,
    parameter int N_SERVO     = 8,
    parameter int SERVO_REGS  = 10,
    parameter int REPLY_WORDS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_start,
    input  logic        host_rnw,
    input  logic        host_stb,
    input  logic [7:0]  bus_din,
    output logic [7:0]  bus_dout,
    output logic        bus_oe,
    output logic        slv_stb,
    output logic        slv_ack,
    output logic        rf_valid,
    output logic        rf_we,
    output logic [7:0]  rf_addr,
    output logic [31:0] rf_wdata,
    input  logic [31:0] rf_rdata
);
    localparam int ADDR_TOP = N_PWM * PWM_REGS + N_ENC * ENC_REGS + SERVO_REGS;
    localparam int REPLY_BYTES = 4 * REPLY_WORDS;
    localparam int CW = ($clog2(REPLY_BYTES) > 3) ? $clog2(REPLY_BYTES) : 3;
    localparam logic [CW-1:0] CMD_LAST   = CW'(5);
    localparam logic [CW-1:0] REPLY_LAST = CW'(REPLY_BYTES - 1);

    typedef struct packed {
        hbus_state_e   st;
        logic [CW-1:0] cnt;
        logic [7:0]    opc;
        logic [7:0]    adr;
        logic [31:0]   dat;
        logic [31:0]   rdat;
        logic [7:0]    stat;
        logic          ack;
        logic          sstb;
        logic          oe;
        logic [7:0]    dout;
    } slave_reg_t;

    slave_reg_t q, d;

    logic [2:0]  sync_w;
    logic        start_s, rnw_s, stb_s;
    logic [7:0]  code_w;
    logic [31:0] info_w;
    logic [31:0] word_w;
    logic [CW-1:0] widx;

    hbus_sync #(.WIDTH(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({host_start, host_rnw, host_stb}),
        .sync_o (sync_w)
    );
    assign {start_s, rnw_s, stb_s} = sync_w;

    hbus_decode #(
        .ADDR_TOP (ADDR_TOP),
        .VER_MAJOR(VER_MAJOR),
        .VER_MINOR(VER_MINOR),
        .N_PWM    (N_PWM),
        .N_ENC    (N_ENC),
        .N_SERVO  (N_SERVO)
    ) u_dec (
        .opc_i (q.opc),
        .adr_i (q.adr),
        .code_o(code_w),
        .info_o(info_w)
    );

    // Reply word and byte selection for the current reply byte
    always_comb begin
        widx = q.cnt >> 2;
        if (widx == '0)
            word_w = q.rdat;
        else if (widx == CW'(1))
            word_w = {24'h0, q.stat};
        else
            word_w = '0;
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                d.ack  = 1'b0;
                d.sstb = 1'b0;
                d.oe   = 1'b0;
                if (start_s) begin
                    d.st  = ST_RECV;
                    d.ack = 1'b1;
                    d.cnt = '0;
                end
            end
            ST_RECV: begin
                if (stb_s && !q.sstb) begin
                    d.sstb = 1'b1;
                    case (q.cnt)
                        CW'(0):  d.opc = bus_din;
                        CW'(1):  d.adr = bus_din;
                        CW'(2):  d.dat[7:0]   = bus_din;
                        CW'(3):  d.dat[15:8]  = bus_din;
                        CW'(4):  d.dat[23:16] = bus_din;
                        default: d.dat[31:24] = bus_din;
                    endcase
                end else if (!stb_s && q.sstb) begin
                    d.sstb = 1'b0;
                    if (q.cnt == CMD_LAST) begin
                        d.st  = ST_EXEC;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_EXEC: begin
                d.stat = code_w;
                d.rdat = '0;
                if (code_w == STS_OK && q.opc == OPC_READ)
                    d.rdat = (q.adr == 8'd0) ? info_w : rf_rdata;
                d.st = ST_SEND;
            end
            ST_SEND: begin
                d.oe = rnw_s;
                if (stb_s && !q.sstb) begin
                    d.sstb = 1'b1;
                    d.dout = word_w[8*q.cnt[1:0] +: 8];
                end else if (!stb_s && q.sstb) begin
                    d.sstb = 1'b0;
                    if (q.cnt == REPLY_LAST) begin
                        d.st  = ST_DONE;
                        d.ack = 1'b0;
                        d.oe  = 1'b0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                d.ack = 1'b0;
                d.oe  = 1'b0;
            end
        endcase
        // Host dropped start: leave the transaction wherever it stands
        if (q.st != ST_IDLE && !start_s) begin
            d.st   = ST_IDLE;
            d.ack  = 1'b0;
            d.sstb = 1'b0;
            d.oe   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign bus_dout = q.dout;
    assign bus_oe   = q.oe;
    assign slv_stb  = q.sstb;
    assign slv_ack  = q.ack;
    assign rf_valid = (q.st == ST_EXEC) && (code_w == STS_OK) && (q.adr != 8'd0);
    assign rf_we    = (q.opc == OPC_WRITE);
    assign rf_addr  = q.adr;
    assign rf_wdata = q.dat;

    p_stb_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slv_stb) |-> $past(stb_s));
    p_stb_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slv_stb) |-> !$past(stb_s));
    p_single_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid |=> !rf_valid);
    p_no_reg0_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid |-> rf_addr != 8'd0);
    p_addr_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid |-> int'(rf_addr) <= ADDR_TOP);
    p_oe_inside_txn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> slv_ack);
    p_ack_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slv_ack) |-> $past(start_s));
endmodule

// File: tb/sim_hbus_slave.sv
module sim_hbus_slave;
    localparam int MAJ = 3, MIN = 7, NP = 2, PR = 3, NE = 1, ER = 4, NS = 5, SR = 3, RW = 3;
    localparam int TOPA = NP * PR + NE * ER + SR;   // 13

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_start = 0, host_rnw = 0, host_stb = 0;
    logic [7:0] bus_din = '0, bus_dout;
    logic bus_oe, slv_stb, slv_ack, rf_valid, rf_we;
    logic [7:0] rf_addr;
    logic [31:0] rf_wdata, rf_rdata;

    always #10 clk = ~clk;   // 50 MHz

    hbus_slave #(.VER_MAJOR(MAJ), .VER_MINOR(MIN), .N_PWM(NP), .PWM_REGS(PR),
                 .N_ENC(NE), .ENC_REGS(ER), .N_SERVO(NS), .SERVO_REGS(SR),
                 .REPLY_WORDS(RW)) u0 (.*);

    // Register file model behind the port
    logic [31:0] mem [0:255];
    int n_wr = 0, n_rd = 0;
    initial for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | i;
    assign rf_rdata = mem[rf_addr];
    always @(posedge clk) if (rf_valid) begin
        if (rf_we) begin mem[rf_addr] <= rf_wdata; n_wr++; end
        else n_rd++;
    end

    int checks = 0, errors = 0;
    typedef struct { logic [31:0] w0; logic [31:0] w1; logic [31:0] xtra; string tag; } item_t;
    item_t exp_q[$], act_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_stb(input logic lvl);
        int n = 0;
        while (slv_stb !== lvl && n < 200) begin @(negedge clk); n++; end
        if (n >= 200) chk(0, "R3 strobe answer timeout", {31'b0, slv_stb}, {31'b0, lvl});
    endtask

    task automatic put_byte(input logic [7:0] b);
        host_rnw = 0; bus_din = b;
        @(negedge clk); host_stb = 1;
        wait_stb(1'b1);
        host_stb = 0;
        wait_stb(1'b0);
    endtask

    bit oe_bad;
    task automatic get_byte(output logic [7:0] b);
        host_rnw = 1;
        @(negedge clk); host_stb = 1;
        wait_stb(1'b1);
        b = bus_dout;
        if (bus_oe !== 1'b1) oe_bad = 1;
        host_stb = 0;
        wait_stb(1'b0);
    endtask

    task automatic txn(input logic [7:0] op, input logic [7:0] adr, input logic [31:0] dat,
                       input logic [31:0] ew0, input logic [31:0] ew1, input string tag);
        item_t e, a;
        logic [7:0] b;
        logic [31:0] w [RW];
        int n = 0;
        e.w0 = ew0; e.w1 = ew1; e.xtra = 0; e.tag = tag;
        exp_q.push_back(e);
        oe_bad = 0;
        host_start = 1;
        while (slv_ack !== 1'b1 && n < 50) begin @(negedge clk); n++; end
        put_byte(op); put_byte(adr);
        for (int i = 0; i < 4; i++) put_byte(dat[8*i +: 8]);
        if (bus_oe !== 1'b0) oe_bad = 1;
        for (int k = 0; k < RW; k++)
            for (int i = 0; i < 4; i++) begin get_byte(b); w[k][8*i +: 8] = b; end
        n = 0;
        while (slv_ack !== 1'b0 && n < 20) begin @(negedge clk); n++; end
        chk(slv_ack === 1'b0, "R2 ack falls after last reply byte", {31'b0, slv_ack}, 0);
        host_start = 0; host_rnw = 0;
        repeat (4) @(negedge clk);
        chk(!oe_bad && bus_oe === 1'b0, "R10 output enable only while host reads reply",
            {31'b0, oe_bad}, 0);
        a.w0 = w[0]; a.w1 = w[1]; a.xtra = 0;
        for (int k = 2; k < RW; k++) a.xtra |= w[k];
        a.tag = tag;
        act_q.push_back(a);
    endtask

    // Monitor: pop expected and actual replies in order and compare
    initial forever begin
        item_t e, a;
        wait (act_q.size() > 0);
        a = act_q.pop_front();
        e = exp_q.pop_front();
        chk(a.w0 === e.w0, {e.tag, " word0"}, a.w0, e.w0);
        chk(a.w1 === e.w1, {e.tag, " status word"}, a.w1, e.w1);
        chk(a.xtra === 32'h0, "R5 extra reply words zero", a.xtra, 0);
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [31:0] INFO = {12'h0, 4'(NS), 4'(NE), 4'(NP), 4'(MIN), 4'(MAJ)};

    initial begin
        int w0;
        repeat (5) @(negedge clk);
        chk(slv_ack === 0 && slv_stb === 0 && bus_oe === 0, "R1 reset outputs low",
            {29'b0, slv_ack, slv_stb, bus_oe}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        txn(8'h01, 8'd0, 0, INFO, 0, "R7 register 0 read");
        txn(8'h02, 8'd1, 32'h1122_3344, 0, 0, "R6 write addr 1");
        chk(n_wr == 1, "R6 one port write", n_wr, 1);
        txn(8'h01, 8'd1, 0, 32'h1122_3344, 0, "R4 R5 byte order readback");
        txn(8'h02, 8'(TOPA), 32'hCAFE_F00D, 0, 0, "R9 write range top");
        txn(8'h01, 8'(TOPA), 0, 32'hCAFE_F00D, 0, "R9 read range top");
        txn(8'h01, 8'd7, 0, 32'hA500_0007, 0, "R6 read untouched");
        w0 = n_wr;
        txn(8'h01, 8'(TOPA + 1), 0, 0, 2, "R9 read past range");
        txn(8'h02, 8'(TOPA + 1), 32'h5555_5555, 0, 2, "R9 write past range");
        txn(8'h5A, 8'd1, 32'h7777_7777, 0, 1, "R8 unknown opcode");
        txn(8'h77, 8'd200, 0, 0, 1, "R8 opcode before address");
        txn(8'h02, 8'd0, 32'hFFFF_FFFF, 0, 3, "R7 write reg 0");
        chk(n_wr == w0, "R7 R8 R9 no port write on error", n_wr, w0);
        txn(8'h01, 8'd0, 0, INFO, 0, "R7 register 0 unchanged");
        txn(8'h01, 8'd1, 0, 32'h1122_3344, 0, "R8 addr 1 untouched by bad opcode");

        // Abort mid-command (R2)
        host_start = 1;
        repeat (6) @(negedge clk);
        put_byte(8'h02); put_byte(8'd1);
        host_start = 0;
        repeat (6) @(negedge clk);
        chk(slv_ack === 0, "R2 abort drops ack", {31'b0, slv_ack}, 0);
        w0 = n_wr;
        txn(8'h01, 8'd1, 0, 32'h1122_3344, 0, "R2 transaction after abort");
        chk(n_wr == w0, "R2 abort made no write", n_wr, w0);

        wait (act_q.size() == 0 && exp_q.size() == 0);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule